// File: doc/BRIEF.md
# Composite-Field Combined Byte Substitution Unit

This block computes the AES byte substitution or its inverse for one byte per clock, with no lookup table anywhere. The input byte is carried into a tower representation, GF((2^4)^2), by a linear change of basis. There it is inverted with 4-bit adders, squarers and multipliers and a 4-bit inverter, and then it is carried back to the standard basis. Both directions share this one inversion path.

A one-bit direction input picks the order of the surrounding steps. In the forward direction the byte is inverted first and then passed through the affine transform. In the inverse direction the inverse affine transform comes first and the inversion follows. The change-of-basis matrices are not written out by hand: elaboration-time functions compute them by searching the standard field for roots of the subfield and extension polynomials. An optional output register, on by default, lets the unit sit as one stage of a pipelined round datapath.

Top module: `cfsbox_unit`

## Requirements
- R1: With mode_i = 0 (forward), dout_o equals the standard AES substitution of the byte applied, for every one of the 256 input values.
- R2: With mode_i = 1 (inverse), dout_o equals the inverse AES substitution of the byte applied, for every one of the 256 input values.
- R3: The zero element inverts to zero, so forward 8'h00 gives 8'h63, and inverse 8'h63 gives 8'h00.
- R4: Feeding the forward result of any byte back in with mode_i = 1 returns the original byte.
- R5: With REG_OUT = 1 (the default), the result for the inputs present before a rising clock edge appears on dout_o after that edge, and dout_o does not change between edges.
- R6: While rst is high at a rising edge, the output register loads 8'h00 whatever din_i and mode_i hold.
- R7: The direction may change on every cycle, and each output reflects the mode_i that was applied together with its own din_i. If din_i and mode_i stay unchanged, dout_o stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| mode_i | input | 1 | Direction select: 0 forward substitution, 1 inverse substitution |
| din_i | input | 8 | Byte to substitute |
| dout_o | output | 8 | Substituted byte, registered when REG_OUT = 1 |

## Verification
The unit holds no state besides the output register, so any fault inside it (a wrong basis column, a wrong nibble multiplier, a misplaced affine tap) shows as a wrong byte on dout_o one clock after the affected input is applied. Most such faults touch many codes but not all of them, so every input is swept in both directions. The sweep is compared against a reference built in the standard field by exponentiation, and the round trip is also checked. A fault in the zero handling or in the direction multiplexers shows only for particular codes or on mode changes, so the zero pair and cycle-by-cycle mode toggling are checked separately.

// File: rtl/cfsbox_pkg.sv
package cfsbox_pkg;

    typedef logic [3:0] nib_t;
    typedef logic [7:0] byte_t;
    // Column k holds the image of input bit k
    typedef logic [7:0][7:0] basis_t;

    typedef enum logic {
        SB_FWD = 1'b0,
        SB_INV = 1'b1
    } sb_mode_e;

    // Tower element hi*x + lo, with hi and lo in GF(2^4)
    typedef struct packed {
        nib_t hi;
        nib_t lo;
    } tower_t;

    localparam nib_t  TW_LAMBDA   = 4'h8;      // y^3, constant term of x^2 + x + lambda
    localparam byte_t AFF_FWD_ADD = 8'h63;
    localparam byte_t AFF_INV_ADD = 8'h05;
    localparam logic [4:0] SUB_POLY = 5'b10011; // y^4 + y + 1

    // ---------------- GF(2^4) arithmetic ----------------
    function automatic nib_t gf16_add(nib_t a, nib_t b);
        return a ^ b;
    endfunction

    function automatic nib_t gf16_sq(nib_t a);
        return {a[3], a[3] ^ a[1], a[2], a[0] ^ a[2]};
    endfunction

    function automatic nib_t gf16_mul(nib_t a, nib_t b);
        logic [6:0] p;
        p = '0;
        for (int i = 0; i < 4; i++) begin
            if (b[2'(i)]) p = p ^ (7'(a) << i);
        end
        for (int k = 6; k >= 4; k--) begin
            if (p[3'(k)]) p = p ^ (7'(SUB_POLY) << (k - 4));
        end
        return p[3:0];
    endfunction

    // a^14 = a^-1 for a != 0, and 0 for a == 0
    function automatic nib_t gf16_inv(nib_t a);
        nib_t a2, a4, a8;
        a2 = gf16_sq(a);
        a4 = gf16_sq(a2);
        a8 = gf16_sq(a4);
        return gf16_mul(gf16_mul(a8, a4), a2);
    endfunction

    // ---------------- standard-field helpers (elaboration only) ----------------
    function automatic byte_t gf256_mul(byte_t a, byte_t b);
        byte_t acc, x;
        acc = '0;
        x   = a;
        for (int i = 0; i < 8; i++) begin
            if (b[3'(i)]) acc = acc ^ x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    function automatic byte_t apply_basis(basis_t m, byte_t v);
        byte_t r;
        r = '0;
        for (int k = 0; k < 8; k++) begin
            if (v[3'(k)]) r = r ^ m[3'(k)];
        end
        return r;
    endfunction

    // Images of the tower basis {1,y,y^2,y^3, x,xy,xy^2,xy^3} in the standard field
    function automatic basis_t tower_basis();
        basis_t col;
        byte_t  g, h, lam, gp, cand, c2, c4;
        g = '0;
        for (int c = 2; c < 256; c++) begin
            cand = byte_t'(c);
            c2   = gf256_mul(cand, cand);
            c4   = gf256_mul(c2, c2);
            if (g == 8'h00 && (c4 ^ cand ^ 8'h01) == 8'h00) g = cand;
        end
        lam = gf256_mul(gf256_mul(g, g), g);
        h = '0;
        for (int c = 2; c < 256; c++) begin
            cand = byte_t'(c);
            if (h == 8'h00 && (gf256_mul(cand, cand) ^ cand ^ lam) == 8'h00) h = cand;
        end
        gp = 8'h01;
        for (int k = 0; k < 4; k++) begin
            col[3'(k)]     = gp;
            col[3'(k + 4)] = gf256_mul(h, gp);
            gp = gf256_mul(gp, g);
        end
        return col;
    endfunction

    function automatic basis_t invert_basis(basis_t m);
        basis_t r;
        r = '0;
        for (int j = 0; j < 8; j++) begin
            for (int c = 0; c < 256; c++) begin
                if (apply_basis(m, byte_t'(c)) == byte_t'(1 << j)) r[3'(j)] = byte_t'(c);
            end
        end
        return r;
    endfunction

    localparam basis_t TOWER_TO_STD = tower_basis();
    localparam basis_t STD_TO_TOWER = invert_basis(TOWER_TO_STD);

    // ---------------- affine steps (standard basis) ----------------
    function automatic byte_t aff_fwd(byte_t b);
        byte_t r;
        for (int i = 0; i < 8; i++) begin
            r[3'(i)] = b[3'(i)] ^ b[3'(i + 4)] ^ b[3'(i + 5)] ^ b[3'(i + 6)] ^ b[3'(i + 7)];
        end
        return r ^ AFF_FWD_ADD;
    endfunction

    function automatic byte_t aff_inv(byte_t b);
        byte_t r;
        for (int i = 0; i < 8; i++) begin
            r[3'(i)] = b[3'(i + 2)] ^ b[3'(i + 5)] ^ b[3'(i + 7)];
        end
        return r ^ AFF_INV_ADD;
    endfunction

endpackage

// File: rtl/cfsbox_affine_stage.sv
module cfsbox_affine_stage
    import cfsbox_pkg::*;
#(
    parameter bit POST = 1'b0   // 0: pre-inversion step, 1: post-inversion step
) (
    input  sb_mode_e mode_i,
    input  byte_t    a_i,
    output byte_t    y_o
);
    generate
        if (POST) begin : g_post
            // forward direction applies the affine map after inversion
            assign y_o = (mode_i == SB_FWD) ? aff_fwd(a_i) : a_i;
        end else begin : g_pre
            // inverse direction applies the inverse affine map before inversion
            assign y_o = (mode_i == SB_INV) ? aff_inv(a_i) : a_i;
        end
    endgenerate
endmodule

// File: rtl/cfsbox_basis_map.sv
module cfsbox_basis_map
    import cfsbox_pkg::*;
#(
    parameter bit TO_TOWER = 1'b1
) (
    input  byte_t a_i,
    output byte_t y_o
);
    localparam basis_t MAP = TO_TOWER ? STD_TO_TOWER : TOWER_TO_STD;

    // each output bit is the parity of the input bits selected by one matrix row
    generate
        for (genvar j = 0; j < 8; j++) begin : g_row
            byte_t row_mask;
            always_comb begin
                for (int k = 0; k < 8; k++) begin
                    row_mask[3'(k)] = MAP[3'(k)][j];
                end
            end
            assign y_o[j] = ^(a_i & row_mask);
        end
    endgenerate
endmodule

// File: rtl/cfsbox_tower_inv.sv
module cfsbox_tower_inv
    import cfsbox_pkg::*;
(
    input  tower_t a_i,
    output tower_t y_o
);
    nib_t sum_n, hi_sq_l, cross_n, det_n, det_inv_n;

    assign sum_n     = gf16_add(a_i.hi, a_i.lo);
    assign hi_sq_l   = gf16_mul(gf16_sq(a_i.hi), TW_LAMBDA);
    assign cross_n   = gf16_mul(a_i.lo, sum_n);
    assign det_n     = gf16_add(hi_sq_l, cross_n);
    assign det_inv_n = gf16_inv(det_n);          // zero determinant yields zero

    assign y_o.hi = gf16_mul(a_i.hi, det_inv_n);
    assign y_o.lo = gf16_mul(sum_n, det_inv_n);
endmodule

// File: rtl/cfsbox_unit.sv
module cfsbox_unit
    import cfsbox_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_i,
    input  logic [7:0] din_i,
    output logic [7:0] dout_o
);
    sb_mode_e mode;
    byte_t    pre_b, tw_in_b, tw_out_b, std_b, post_b;
    tower_t   tw_in, tw_out;

    assign mode = sb_mode_e'(mode_i);

    cfsbox_affine_stage #(.POST(1'b0)) u_pre (
        .mode_i (mode),
        .a_i    (din_i),
        .y_o    (pre_b)
    );

    cfsbox_basis_map #(.TO_TOWER(1'b1)) u_to_tower (
        .a_i (pre_b),
        .y_o (tw_in_b)
    );

    assign tw_in = tower_t'(tw_in_b);

    cfsbox_tower_inv u_inv (
        .a_i (tw_in),
        .y_o (tw_out)
    );

    assign tw_out_b = byte_t'(tw_out);

    cfsbox_basis_map #(.TO_TOWER(1'b0)) u_to_std (
        .a_i (tw_out_b),
        .y_o (std_b)
    );

    cfsbox_affine_stage #(.POST(1'b1)) u_post (
        .mode_i (mode),
        .a_i    (std_b),
        .y_o    (post_b)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) dout_o <= '0;
                else     dout_o <= post_b;
            end
        end else begin : g_comb
            assign dout_o = post_b;
        end
    endgenerate
endmodule

// File: rtl/cfsbox_chk.sv
module cfsbox_chk (
    input logic       clk,
    input logic       rst,
    input logic       mode_i,
    input logic [7:0] din_i,
    input logic [7:0] dout_o
);
    logic prev_ok, prev2_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_ok  <= 1'b0;
            prev2_ok <= 1'b0;
        end else begin
            prev_ok  <= 1'b1;
            prev2_ok <= prev_ok;
        end
    end

    // R6
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> dout_o == 8'h00);

    // R3
    zero_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && !$past(mode_i) && $past(din_i) == 8'h00) |-> dout_o == 8'h63);

    // R3
    zero_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && $past(mode_i) && $past(din_i) == 8'h63) |-> dout_o == 8'h00);

    // R1
    fwd_nofix_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && !$past(mode_i)) |-> (dout_o != $past(din_i) && dout_o != ~$past(din_i)));

    // R2
    inv_nofix_chk: assert property (@(posedge clk) disable iff (rst)
        (prev_ok && $past(mode_i)) |-> (dout_o != $past(din_i) && dout_o != ~$past(din_i)));

    // R7
    steady_out_chk: assert property (@(posedge clk) disable iff (rst)
        (prev2_ok && $past(din_i) == $past(din_i, 2) && $past(mode_i) == $past(mode_i, 2))
        |-> $stable(dout_o));
endmodule

bind cfsbox_unit cfsbox_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .mode_i (mode_i),
    .din_i  (din_i),
    .dout_o (dout_o)
);

// File: tb/tb_cfsbox_unit.sv
`timescale 1ns/1ps
module tb_cfsbox_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] inv_tab [256];

    always #4 clk = ~clk;   // 125 MHz

    cfsbox_unit dut (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode),
        .din_i  (din),
        .dout_o (dout)
    );

    // ---- reference in the standard field ----
    function automatic logic [7:0] r_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] acc, x;
        acc = 0; x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc ^= x;
            x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
        end
        return acc;
    endfunction

    function automatic logic [7:0] r_recip(logic [7:0] a);
        logic [7:0] p;
        p = 8'h01;
        for (int i = 0; i < 254; i++) p = r_mul(p, a);
        return p;   // a^254, zero stays zero
    endfunction

    function automatic logic [7:0] rotl(logic [7:0] b, int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    function automatic logic [7:0] r_fwd(logic [7:0] a);
        logic [7:0] q;
        q = r_recip(a);
        return q ^ rotl(q, 1) ^ rotl(q, 2) ^ rotl(q, 3) ^ rotl(q, 4) ^ 8'h63;
    endfunction

    task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    // R6: reset clears, also when asserted mid-stream
    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; din = 8'h5A; mode = 1'b0;
        repeat (2) @(negedge clk);
        check(dout == 8'h00, "R6 reset value", dout, 8'h00);
        rst = 1'b0;
        @(negedge clk);
        check(dout == r_fwd(8'h5A), "R6 after release", dout, r_fwd(8'h5A));
        rst = 1'b1; din = 8'hC3; mode = 1'b1;
        @(negedge clk);
        check(dout == 8'h00, "R6 mid-stream reset", dout, 8'h00);
        rst = 1'b0;
    endtask

    // R1 / R2: pipelined sweep of all inputs
    task automatic t_sweep(input logic m);
        logic [7:0] exp_prev;
        exp_prev = 0;
        for (int i = 0; i <= 256; i++) begin
            @(negedge clk);
            if (i > 0) check(dout == exp_prev, m ? "R2 inverse sweep" : "R1 forward sweep", dout, exp_prev);
            if (i < 256) begin
                mode = m; din = 8'(i);
                exp_prev = m ? inv_tab[i] : r_fwd(8'(i));
            end
        end
    endtask

    // R3: zero handling
    task automatic t_zero();
        @(negedge clk); mode = 1'b0; din = 8'h00;
        @(negedge clk); check(dout == 8'h63, "R3 forward zero", dout, 8'h63);
        mode = 1'b1; din = 8'h63;
        @(negedge clk); check(dout == 8'h00, "R3 inverse of 63", dout, 8'h00);
    endtask

    // R4: round trip through the device
    task automatic t_roundtrip();
        logic [7:0] y;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk); mode = 1'b0; din = 8'(i);
            @(negedge clk); y = dout; mode = 1'b1; din = y;
            @(negedge clk); check(dout == 8'(i), "R4 round trip", dout, 8'(i));
        end
    endtask

    // R5: output moves only at the clock edge
    task automatic t_latency();
        @(negedge clk); mode = 1'b0; din = 8'h00;
        @(negedge clk);
        din = 8'h01;
        #1 check(dout == 8'h63, "R5 held before edge", dout, 8'h63);
        @(negedge clk);
        check(dout == 8'h7C, "R5 updated after edge", dout, 8'h7C);
    endtask

    // R7: per-cycle direction changes, and steady inputs give a steady output
    task automatic t_toggle();
        logic [7:0] exp_prev, v;
        exp_prev = 0;
        for (int i = 0; i <= 40; i++) begin
            @(negedge clk);
            if (i > 0) check(dout == exp_prev, "R7 mode toggle", dout, exp_prev);
            if (i < 40) begin
                v = 8'(i * 37 + 11);
                mode = i[0]; din = v;
                exp_prev = i[0] ? inv_tab[v] : r_fwd(v);
            end
        end
        @(negedge clk); mode = 1'b1; din = 8'hA7;
        repeat (3) @(negedge clk);
        check(dout == inv_tab[8'hA7], "R7 steady output", dout, inv_tab[8'hA7]);
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=00 expected=01");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) inv_tab[r_fwd(8'(i))] = 8'(i);
        repeat (3) @(negedge clk);
        t_reset();
        t_latency();
        t_zero();
        t_sweep(1'b0);
        t_sweep(1'b1);
        t_roundtrip();
        t_toggle();
        finish_run();
    end
endmodule